// File: doc/BRIEF.md
# Debug Register Access Command Engine

This block sits behind a serial debug shifter and turns 16-bit command words into accesses to the processor's sixteen general registers: eight address registers and eight data registers. The shifter moves one word in each transfer slot and signals the slot with a one-cycle `slot` strobe. In that same slot it shifts out the response word that the engine prepared earlier. Every response word carries a status bit: 0 marks a normal result, and 1 marks a not-ready, bus-error or illegal-command answer.

A read command requests the selected register over a request/acknowledge port. The result comes back as two words, upper half first. A write command takes two operand words, upper half first, and then issues a single 32-bit write. Register accesses are only made while the core reports that it is halted. Any word that is not a read or write command is answered as illegal and has no other effect. The register port may take one to four cycles to acknowledge. Until it does, every slot is answered with not-ready.

Top module: `dbg_reg_cmd`

## Requirements
- R1: A synchronous active-high reset returns the engine to waiting for a command and discards any partly received write. The pending response becomes 0x0000 with status 1, and `rf_req` is low.
- R2: A word matching 0x218X is a register read. Bit 3 selects an address register when 1 and a data register when 0, and bits 2:0 give the register number. While halted, the engine raises `rf_req` with `rf_we`=0 and `rf_sel`={bit 3, bits 2:0}.
- R3: After a read is acknowledged, the next two slots return register bits 31:16 and then bits 15:0, each with status 0.
- R4: While a register request is waiting for its acknowledge, every slot returns 0x0000 with status 1, and the word shifted in during that slot is discarded.
- R5: A word matching 0x208X is a register write, with the register selected as in R2. The next two slot words are bits 31:16 and then bits 15:0. While halted, the engine then raises `rf_req` with `rf_we`=1 and `rf_wdata` holding all 32 bits.
- R6: Once a write is acknowledged, the next slot returns 0xFFFF with status 0.
- R7: If the core is not halted, no request is made and the next slot returns 0x0001 with status 1. For a read, halted is sampled in the command slot. For a write, it is sampled in the final operand slot.
- R8: Any other command word changes no register, and the next slot returns 0xFFFF with status 1.
- R9: `rf_req` stays high, with `rf_sel`, `rf_we` and `rf_wdata` unchanged, until `rf_ack`. It falls in the cycle after `rf_ack`.
- R10: The slot that shifts out a read's low result word also accepts the next command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halted | input | 1 | Core is halted |
| slot | input | 1 | One-cycle strobe for a transfer slot |
| cmd_word | input | 16 | Word shifted in during the slot |
| rsp_word | output | 16 | Response word shifted out during the slot |
| rsp_stat | output | 1 | Status bit of the response word |
| rf_req | output | 1 | Register access request |
| rf_we | output | 1 | Request is a write |
| rf_sel | output | 4 | {address select, register number} |
| rf_wdata | output | 32 | Write data |
| rf_rdata | input | 32 | Read data, valid with `rf_ack` |
| rf_ack | input | 1 | Access done, one-cycle pulse |

## Verification
A response word is prepared at the clock edge of the slot that causes it, so it is due in the next slot and never in the same one. `rf_req` rises at the edge of the command slot, or of the final operand slot for a write. A read's upper result word is ready one edge after `rf_ack`, and `rf_ack` arrives a set number of cycles (1 to 4) after the request. The bench keeps a behavioural model that is stepped at the same edges and compares the outputs at every falling edge. The scripted slot checks are placed from this cycle count: they either follow back to back to hit the not-ready window, or leave a gap longer than the acknowledge latency to reach the result words.

// File: rtl/dbg_reg_cmd.sv
module dbg_reg_cmd (
  input  logic        clk,
  input  logic        rst,
  input  logic        halted,
  input  logic        slot,
  input  logic [15:0] cmd_word,
  output logic [15:0] rsp_word,
  output logic        rsp_stat,
  output logic        rf_req,
  output logic        rf_we,
  output logic [3:0]  rf_sel,
  output logic [31:0] rf_wdata,
  input  logic [31:0] rf_rdata,
  input  logic        rf_ack
);
  localparam logic [15:0] NRDY = 16'h0000;
  localparam logic [15:0] BERR = 16'h0001;
  localparam logic [15:0] ALL1 = 16'hFFFF;

  typedef enum logic [2:0] {IDLE, RD_WAIT, RD_HI, RD_LO, WR_HI, WR_LO, WR_WAIT} st_t;
  st_t st;
  logic [15:0] lo_q;

  wire op_ok  = cmd_word[15:12] == 4'h2 && cmd_word[7:4] == 4'h8;
  wire is_rd  = op_ok && cmd_word[11:8] == 4'h1;
  wire is_wr  = op_ok && cmd_word[11:8] == 4'h0;
  wire accept = slot && (st == IDLE || st == RD_LO);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= IDLE;
      rsp_word <= NRDY;
      rsp_stat <= 1'b1;
      rf_req   <= 1'b0;
      rf_we    <= 1'b0;
      rf_sel   <= '0;
      rf_wdata <= '0;
      lo_q     <= '0;
    end else if (accept) begin
      rsp_stat <= 1'b1;
      if (is_rd) begin
        rf_sel <= cmd_word[3:0];
        if (halted) begin
          rf_req   <= 1'b1;
          rf_we    <= 1'b0;
          rsp_word <= NRDY;
          st       <= RD_WAIT;
        end else begin
          rsp_word <= BERR;
          st       <= IDLE;
        end
      end else if (is_wr) begin
        rf_sel   <= cmd_word[3:0];
        rsp_word <= NRDY;
        st       <= WR_HI;
      end else begin
        rsp_word <= ALL1;
        st       <= IDLE;
      end
    end else begin
      case (st)
        RD_WAIT: if (rf_ack) begin
          rf_req   <= 1'b0;
          lo_q     <= rf_rdata[15:0];
          rsp_word <= rf_rdata[31:16];
          rsp_stat <= 1'b0;
          st       <= RD_HI;
        end
        RD_HI: if (slot) begin
          rsp_word <= lo_q;
          st       <= RD_LO;
        end
        WR_HI: if (slot) begin
          rf_wdata[31:16] <= cmd_word;
          st              <= WR_LO;
        end
        WR_LO: if (slot) begin
          rf_wdata[15:0] <= cmd_word;
          if (halted) begin
            rf_req <= 1'b1;
            rf_we  <= 1'b1;
            st     <= WR_WAIT;
          end else begin
            rsp_word <= BERR;
            st       <= IDLE;
          end
        end
        WR_WAIT: if (rf_ack) begin
          rf_req   <= 1'b0;
          rf_we    <= 1'b0;
          rsp_word <= ALL1;
          rsp_stat <= 1'b0;
          st       <= IDLE;
        end
        default: ;
      endcase
    end
  end
endmodule

module dbg_reg_cmd_chk (
  input logic        clk,
  input logic        rst,
  input logic        halted,
  input logic        rsp_stat,
  input logic        rf_req,
  input logic        rf_ack,
  input logic        rf_we,
  input logic [3:0]  rf_sel,
  input logic [31:0] rf_wdata
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_req && !rf_ack) |=> rf_req);
  // R9
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    rf_ack |=> !rf_req);
  // R9
  req_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_req && !rf_ack) |=> ($stable(rf_sel) && $stable(rf_we) && $stable(rf_wdata)));
  // R7
  req_halted_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rf_req) |-> $past(halted));
  // R3
  ok_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rsp_stat) |-> $past(rf_ack));
endmodule

bind dbg_reg_cmd dbg_reg_cmd_chk chk (
  .clk(clk), .rst(rst), .halted(halted), .rsp_stat(rsp_stat),
  .rf_req(rf_req), .rf_ack(rf_ack), .rf_we(rf_we),
  .rf_sel(rf_sel), .rf_wdata(rf_wdata)
);

// File: tb/dbg_reg_cmd_test.sv
module dbg_reg_cmd_test;
  logic clk = 0, rst = 1, halted = 1, slot = 0;
  logic [15:0] cmd_word = 0;
  logic [15:0] rsp_word;
  logic rsp_stat, rf_req, rf_we, rf_ack;
  logic [3:0] rf_sel;
  logic [31:0] rf_wdata, rf_rdata;
  int checks = 0, errors = 0;
  int lat = 3;
  int cnt = 0;
  string tag = "R1";
  logic [31:0] core[16];
  logic [31:0] shadow[16];

  always #10 clk = ~clk;

  dbg_reg_cmd uut (.clk(clk), .rst(rst), .halted(halted), .slot(slot),
    .cmd_word(cmd_word), .rsp_word(rsp_word), .rsp_stat(rsp_stat),
    .rf_req(rf_req), .rf_we(rf_we), .rf_sel(rf_sel), .rf_wdata(rf_wdata),
    .rf_rdata(rf_rdata), .rf_ack(rf_ack));

  // core model: register file with programmable acknowledge latency
  initial begin
    rf_ack = 0; rf_rdata = 0;
    for (int i = 0; i < 16; i++) begin
      core[i]   = {16'h1000 + 16'(i), 16'hE000 + 16'(i)};
      shadow[i] = core[i];
    end
  end
  always @(posedge clk) begin
    if (rst) begin rf_ack <= 0; cnt <= 0; end
    else if (rf_req && !rf_ack) begin
      if (cnt == lat - 1) begin
        rf_ack <= 1; cnt <= 0;
        if (rf_we) core[rf_sel] <= rf_wdata;
        rf_rdata <= core[rf_sel];
      end else cnt <= cnt + 1;
    end else rf_ack <= 0;
  end

  // behavioural reference of the expected outputs
  int ph = 0;
  logic [15:0] e_w = 0, m_hi = 0, m_lo = 0;
  logic e_s = 1, e_req = 0;
  logic [3:0] m_sel = 0;
  always @(posedge clk) begin
    if (rst) begin ph = 0; e_w = 16'h0000; e_s = 1; e_req = 0; end
    else if (ph == 1 || ph == 6) begin
      if (rf_ack) begin
        e_req = 0; e_s = 0;
        if (ph == 1) begin e_w = shadow[m_sel][31:16]; ph = 2; end
        else begin shadow[m_sel] = {m_hi, m_lo}; e_w = 16'hFFFF; ph = 0; end
      end
    end else if (slot) begin
      if (ph == 2) begin e_w = shadow[m_sel][15:0]; ph = 3; end
      else if (ph == 4) begin m_hi = cmd_word; ph = 5; end
      else if (ph == 5) begin
        m_lo = cmd_word;
        if (halted) begin e_req = 1; ph = 6; end
        else begin e_w = 16'h0001; e_s = 1; ph = 0; end
      end else begin
        e_s = 1;
        if ((cmd_word & 16'hFFF0) == 16'h2180) begin
          m_sel = cmd_word[3:0];
          if (halted) begin e_req = 1; e_w = 16'h0000; ph = 1; end
          else begin e_w = 16'h0001; ph = 0; end
        end else if ((cmd_word & 16'hFFF0) == 16'h2080) begin
          m_sel = cmd_word[3:0]; e_w = 16'h0000; ph = 4;
        end else begin e_w = 16'hFFFF; ph = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (rsp_word !== e_w || rsp_stat !== e_s || rf_req !== e_req) begin
        errors++;
        $display("FAIL %s per-cycle: got %h/%b req %b, expected %h/%b req %b",
                 tag, rsp_word, rsp_stat, rf_req, e_w, e_s, e_req);
      end
    end
  end

  task automatic chk(input string r, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  // drive one slot; the response seen in the slot is checked
  task automatic xfer(input logic [15:0] w, input logic [15:0] ew, input logic es, input string r);
    tag = r;
    slot = 1; cmd_word = w;
    chk(r, {19'd0, rsp_stat, rsp_word}, {19'd0, es, ew});
    @(negedge clk);
    slot = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    tag = "R1";
    chk("R1", {18'd0, rf_req, rsp_stat, rsp_word}, {18'd0, 1'b0, 1'b1, 16'h0000});

    // read D3
    xfer(16'h2183, 16'h0000, 1, "R2");
    chk("R2", {30'd0, rf_req, rf_we, rf_sel}, {30'd0, 1'b1, 1'b0, 4'h3});
    xfer(16'h2185, 16'h0000, 1, "R4");
    idle(8);
    xfer(16'h0000, 16'h1003, 0, "R3");
    xfer(16'h218D, 16'hE003, 0, "R10");
    idle(8);
    xfer(16'h0000, 16'h100D, 0, "R3");
    xfer(16'h1234, 16'hE00D, 0, "R10");
    xfer(16'h0000, 16'hFFFF, 1, "R8");

    // write D5
    xfer(16'h2085, 16'hFFFF, 1, "R8");
    xfer(16'hCAFE, 16'h0000, 1, "R5");
    xfer(16'hBEEF, 16'h0000, 1, "R5");
    chk("R5", {rf_req, rf_we, rf_sel, rf_wdata}, {1'b1, 1'b1, 4'h5, 32'hCAFEBEEF});
    idle(8);
    xfer(16'h2185, 16'hFFFF, 0, "R6");
    idle(8);
    xfer(16'h0000, 16'hCAFE, 0, "R5");
    xfer(16'h0000, 16'hBEEF, 0, "R5");

    // core running
    halted = 0;
    xfer(16'h218A, 16'hFFFF, 1, "R8");
    chk("R7", {35'd0, rf_req}, 36'd0);
    xfer(16'h208A, 16'h0001, 1, "R7");
    xfer(16'h1111, 16'h0000, 1, "R7");
    xfer(16'h2222, 16'h0000, 1, "R7");
    idle(3);
    chk("R7", {35'd0, rf_req}, 36'd0);
    xfer(16'h0000, 16'h0001, 1, "R7");
    halted = 1;
    xfer(16'h218A, 16'hFFFF, 1, "R7");
    idle(8);
    xfer(16'h0000, 16'h100A, 0, "R7");
    xfer(16'h0000, 16'hE00A, 0, "R7");

    // reset during a partial write
    xfer(16'h2082, 16'hFFFF, 1, "R1");
    xfer(16'h5555, 16'h0000, 1, "R1");
    rst = 1; tag = "R1";
    idle(2);
    rst = 0;
    xfer(16'h2182, 16'h0000, 1, "R1");
    chk("R1", {30'd0, rf_req, rf_we, rf_sel}, {30'd0, 1'b1, 1'b0, 4'h2});
    idle(8);
    xfer(16'h0000, 16'h1002, 0, "R1");
    xfer(16'h0000, 16'hE002, 0, "R1");

    // latency 1
    lat = 1;
    xfer(16'h218F, 16'hFFFF, 1, "R8");
    idle(3);
    xfer(16'h0000, 16'h100F, 0, "R3");
    xfer(16'h0000, 16'hE00F, 0, "R3");

    // latency 4: not-ready window
    lat = 4;
    xfer(16'h2181, 16'hFFFF, 1, "R8");
    xfer(16'h2084, 16'h0000, 1, "R4");
    xfer(16'h2084, 16'h0000, 1, "R4");
    xfer(16'h2084, 16'h0000, 1, "R4");
    xfer(16'h2084, 16'h0000, 1, "R4");
    idle(4);
    xfer(16'h0000, 16'h1001, 0, "R3");
    xfer(16'h0000, 16'hE001, 0, "R3");
    idle(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule